// File: doc/BRIEF.md
# BT.656 Stream Timing Decoder

This block takes a 27 MHz byte stream of interleaved 4:2:2 video with embedded timing codes. It recovers the line and field timing from that stream alone. Each timing code is three fixed preamble bytes (0xFF, 0x00, 0x00) followed by a status byte. The status byte carries the field bit, the vertical-blank bit and a bit that tells a start-of-active-video code from an end-of-active-video code. Four protection bits in the same byte guard those three bits.

Within the active part of a line, chroma and luma bytes alternate in the order blue-difference, luma, red-difference, luma. The decoder pairs each luma byte with the chroma byte just before it and marks the pair with a one-cycle valid pulse. An active line carries 720 luma, 360 blue-difference and 360 red-difference samples in 1440 clocks. The decoder also gives start-of-line and end-of-line strobes and holds field and vertical-blank levels.

The stream can enter on either byte of a 16-bit bus, chosen by a control bit. A second control bit chooses between the 525-line standard (1716 clocks per line) and the 625-line standard (1728 clocks per line). The decoder measures the spacing of end-of-active-video codes against that length and reports a line-length error. A corrupt timing code is reported and otherwise ignored.

Top module: `bt656_timing_rx`

## Requirements
- R1: While rst is high and in the cycle after it falls, every output is 0.
- R2: A timing code is the byte sequence 0xFF, 0x00, 0x00, S. In S, bit 6 is field, bit 5 is vertical blank and bit 4 is 0 for start-of-active-video and 1 for end-of-active-video. A valid start code pulses line_start and a valid end code pulses line_end for one cycle. If S is sampled at clock edge n, the strobe is high after edge n+1.
- R3: Every valid timing code loads field and vblank from bits 6 and 5 of S. Both hold their values until the next valid code.
- R4: S is valid only if bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}, where F, V and H are bits 6, 5 and 4. An invalid S gives a one-cycle prot_err pulse with the same latency as the strobes. It causes no strobe, and field and vblank keep their values.
- R5: After a valid start code with V=0, the next 1440 bytes are taken as Cb, Y, Cr, Y and so on. Each Y byte gives one sample_valid pulse, with luma set to that Y and chroma set to the chroma byte just before it. chroma_is_cr is 0 after Cb and 1 after Cr. A Y byte sampled at edge n appears after edge n+1. Each line gives 720 pulses, and sample_valid is never high on two cycles in a row.
- R6: After a valid start code with V=1, sample_valid stays low for that line.
- R7: With lane_hi=0 the stream is taken from din[7:0]; with lane_hi=1 it is taken from din[15:8]. The other byte has no effect on any output.
- R8: std625=0 sets the expected line length to 1716 clocks; std625=1 sets it to 1728 clocks.
- R9: At each valid end code after the first one since reset, len_err pulses together with line_end if the clocks since the previous valid end code differ from the expected line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 16 | Input bus carrying the stream in one byte |
| lane_hi | input | 1 | 1 takes the stream from din[15:8], 0 from din[7:0] |
| std625 | input | 1 | 1 selects the 1728-clock line, 0 the 1716-clock line |
| luma | output | 8 | Luma sample |
| chroma | output | 8 | Chroma sample paired with luma |
| chroma_is_cr | output | 1 | Chroma is red-difference (1) or blue-difference (0) |
| sample_valid | output | 1 | One-cycle pulse for each luma/chroma pair |
| field | output | 1 | Field bit of the last valid code |
| vblank | output | 1 | Vertical-blank bit of the last valid code |
| line_start | output | 1 | Pulse for a valid start-of-active-video code |
| line_end | output | 1 | Pulse for a valid end-of-active-video code |
| prot_err | output | 1 | Pulse for a timing code with bad protection |
| len_err | output | 1 | Pulse for a line of the wrong length |

## Verification
A wrong preamble history or protection decode shows up two cycles after the status byte, as a missing or extra strobe or a field/vblank level that is wrong or unchanged. A slip in the active-byte counter swaps luma and chroma or the Cb/Cr tag from the first sample of the line, and changes the count of 720 valid pulses by the end of it. A fault in the line-length counter stays hidden until the following end code, one full line later, where len_err is raised or left low. The directed scenarios therefore check every sample against an independent pattern model and check the strobe counts at the line boundaries.

// File: rtl/bt656_rx_pkg.sv
package bt656_rx_pkg;

  localparam logic [7:0] PREAMBLE_FF = 8'hFF;
  localparam logic [7:0] PREAMBLE_00 = 8'h00;

  typedef struct packed {
    logic f;  // field
    logic v;  // vertical blank
    logic h;  // 1 = end of active video
  } trs_flags_t;

  function automatic logic [3:0] trs_protect(input trs_flags_t t);
    return {t.v ^ t.h, t.f ^ t.h, t.f ^ t.v, t.f ^ t.v ^ t.h};
  endfunction

endpackage

// File: rtl/bt656_lane_select.sv
module bt656_lane_select #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*BYTE_W-1:0] din,
  input  logic                    lane_hi,
  output logic [BYTE_W-1:0]       byte_q
);

  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = din[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else     byte_q <= lane_hi ? lane_bytes[LANES-1] : lane_bytes[0];
  end

endmodule

// File: rtl/bt656_trs_detect.sv
module bt656_trs_detect
  import bt656_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_q,
  output logic       hit,
  output trs_flags_t flags,
  output logic       perr
);

  // the three bytes seen before byte_q, oldest in hist2
  logic [7:0] hist0, hist1, hist2;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist0 <= '0;
      hist1 <= '0;
      hist2 <= '0;
    end else begin
      hist0 <= byte_q;
      hist1 <= hist0;
      hist2 <= hist1;
    end
  end

  always_comb begin
    hit   = (hist2 == PREAMBLE_FF) && (hist1 == PREAMBLE_00) &&
            (hist0 == PREAMBLE_00);
    flags = trs_flags_t'(byte_q[6:4]);
    perr  = !byte_q[7] || (byte_q[3:0] != trs_protect(flags));
  end

endmodule

// File: rtl/bt656_line_len_check.sv
module bt656_line_len_check #(
  parameter int LINE_A = 1716,
  parameter int LINE_B = 1728,
  parameter int CNT_W  = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic eav,
  input  logic sel_b,
  output logic len_err
);

  localparam logic [CNT_W-1:0] LEN_A = CNT_W'(LINE_A);
  localparam logic [CNT_W-1:0] LEN_B = CNT_W'(LINE_B);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [CNT_W-1:0] expect_len;

  assign expect_len = sel_b ? LEN_B : LEN_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      armed   <= 1'b0;
      len_err <= 1'b0;
    end else begin
      len_err <= 1'b0;
      if (eav) begin
        len_err <= armed && (cnt != expect_len);
        armed   <= 1'b1;
        cnt     <= CNT_W'(1);
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  first_eav_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (eav && !armed) |=> !len_err);

endmodule

// File: rtl/bt656_timing_rx.sv
module bt656_timing_rx
  import bt656_rx_pkg::*;
#(
  parameter int ACTIVE_BYTES = 1440,
  parameter int LINE_525     = 1716,
  parameter int LINE_625     = 1728
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] din,
  input  logic        lane_hi,
  input  logic        std625,
  output logic [7:0]  luma,
  output logic [7:0]  chroma,
  output logic        chroma_is_cr,
  output logic        sample_valid,
  output logic        field,
  output logic        vblank,
  output logic        line_start,
  output logic        line_end,
  output logic        prot_err,
  output logic        len_err
);

  localparam int LINE_MAX = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int CNT_W    = $clog2(LINE_MAX + 2);
  localparam int ACT_W    = $clog2(ACTIVE_BYTES);
  localparam logic [ACT_W-1:0] ACT_LAST = ACT_W'(ACTIVE_BYTES - 1);

  logic [7:0]       byte_q;
  logic             hit;
  trs_flags_t       flags;
  logic             perr;
  logic             in_active;
  logic [ACT_W-1:0] act_cnt;
  logic [7:0]       chroma_hold;

  bt656_lane_select #(.BYTE_W(8), .LANES(2)) u_lane (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .lane_hi(lane_hi),
    .byte_q (byte_q)
  );

  bt656_trs_detect u_trs (
    .clk   (clk),
    .rst   (rst),
    .byte_q(byte_q),
    .hit   (hit),
    .flags (flags),
    .perr  (perr)
  );

  bt656_line_len_check #(
    .LINE_A(LINE_525),
    .LINE_B(LINE_625),
    .CNT_W (CNT_W)
  ) u_len (
    .clk    (clk),
    .rst    (rst),
    .eav    (hit && !perr && flags.h),
    .sel_b  (std625),
    .len_err(len_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      luma         <= '0;
      chroma       <= '0;
      chroma_is_cr <= 1'b0;
      sample_valid <= 1'b0;
      field        <= 1'b0;
      vblank       <= 1'b0;
      line_start   <= 1'b0;
      line_end     <= 1'b0;
      prot_err     <= 1'b0;
      in_active    <= 1'b0;
      act_cnt      <= '0;
      chroma_hold  <= '0;
    end else begin
      line_start   <= 1'b0;
      line_end     <= 1'b0;
      prot_err     <= 1'b0;
      sample_valid <= 1'b0;
      if (hit) begin
        if (perr) begin
          prot_err <= 1'b1;
        end else begin
          field  <= flags.f;
          vblank <= flags.v;
          if (flags.h) begin
            line_end  <= 1'b1;
            in_active <= 1'b0;
          end else begin
            line_start <= 1'b1;
            in_active  <= !flags.v;
            act_cnt    <= '0;
          end
        end
      end else if (in_active) begin
        act_cnt <= act_cnt + 1'b1;
        if (act_cnt == ACT_LAST) in_active <= 1'b0;
        if (!act_cnt[0]) begin
          chroma_hold <= byte_q;
        end else begin
          luma         <= byte_q;
          chroma       <= chroma_hold;
          chroma_is_cr <= act_cnt[1];
          sample_valid <= 1'b1;
        end
      end
    end
  end

  // R5
  no_back_to_back_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R6
  no_valid_in_vblank_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> !vblank);

  // R2
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_start && line_end));

  // R4
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    prot_err |-> (!line_start && !line_end && $stable(field) && $stable(vblank)));

  // R9
  len_err_on_eol_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |-> line_end);

endmodule

// File: tb/bt656_timing_rx_test.sv
module bt656_timing_rx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic        lane_hi = 1'b0;
  logic        std625 = 1'b0;
  logic [7:0]  luma, chroma;
  logic        chroma_is_cr, sample_valid, field, vblank;
  logic        line_start, line_end, prot_err, len_err;

  bt656_timing_rx uut (
    .clk(clk), .rst(rst), .din(din), .lane_hi(lane_hi), .std625(std625),
    .luma(luma), .chroma(chroma), .chroma_is_cr(chroma_is_cr),
    .sample_valid(sample_valid), .field(field), .vblank(vblank),
    .line_start(line_start), .line_end(line_end),
    .prot_err(prot_err), .len_err(len_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] junk = 8'h5A;

  // monitor counters
  int n_valid, n_sol, n_eol, n_perr, n_len, n_bad, k;
  int bad_act, bad_exp;

  function automatic logic [7:0] ypat(int i);  return 8'(16 + (i % 200)); endfunction
  function automatic logic [7:0] cbpat(int j); return 8'(40 + (j % 150)); endfunction
  function automatic logic [7:0] crpat(int j); return 8'(60 + (j % 150)); endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (line_start) begin n_sol++; k = 0; end
      if (line_end) n_eol++;
      if (prot_err) n_perr++;
      if (len_err) n_len++;
      if (sample_valid) begin
        logic [7:0] ec;
        ec = (k % 2 == 0) ? cbpat(k / 2) : crpat(k / 2);
        if (luma !== ypat(k) || chroma !== ec || chroma_is_cr !== 1'(k % 2)) begin
          if (n_bad == 0) begin
            bad_act = {luma, chroma};
            bad_exp = {ypat(k), ec};
          end
          n_bad++;
        end
        n_valid++;
        k++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_sol = 0; n_eol = 0; n_perr = 0; n_len = 0; n_bad = 0;
    k = 0; bad_act = 0; bad_exp = 0;
  endtask

  task automatic put(input logic [7:0] b);
    din  <= lane_hi ? {b, junk} : {junk, b};
    junk <= junk + 8'd37;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    put(b);
  endtask

  function automatic logic [7:0] status(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic send_raw_code(input logic [7:0] s);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(s);
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) send_byte((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic send_active();
    for (int i = 0; i < 360; i++) begin
      send_byte(cbpat(i)); send_byte(ypat(2 * i));
      send_byte(crpat(i)); send_byte(ypat(2 * i + 1));
    end
  endtask

  // one line starting with its end code: EAV, blanking, SAV, active part
  task automatic send_line(input bit f, input bit v, input int total);
    send_raw_code(status(f, v, 1'b1));
    send_fill(total - 1440 - 8);
    send_raw_code(status(f, v, 1'b0));
    if (v) send_fill(1440);
    else   send_active();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din <= '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_counts();
  endtask

  task automatic t_reset();
    logic [24:0] all;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    all = {luma, chroma, chroma_is_cr, sample_valid, field, vblank,
           line_start, line_end, prot_err, len_err};
    chk(all == '0, "R1", "outputs during reset", int'(all), 0);
    rst = 1'b0;
    @(negedge clk);
    all = {luma, chroma, chroma_is_cr, sample_valid, field, vblank,
           line_start, line_end, prot_err, len_err};
    chk(all == '0, "R1", "outputs after reset", int'(all), 0);
    clear_counts();
  endtask

  task automatic t_latency();
    bit s0, s1, v0, v1;
    logic [7:0] l1, c1;
    do_reset();
    lane_hi = 1'b0; std625 = 1'b0;
    send_raw_code(status(1'b0, 1'b0, 1'b0));  // status driven before edge n
    @(negedge clk); s0 = line_start; put(cbpat(0));   // after edge n
    @(negedge clk); s1 = line_start; put(ypat(0));    // after edge n+1
    @(negedge clk); v0 = sample_valid; put(crpat(0));
    @(negedge clk); v1 = sample_valid; l1 = luma; c1 = chroma; put(ypat(1));
    chk(!s0 && s1, "R2", "line_start latency (s0,s1)", {s0, s1}, 1);
    chk(!v0 && v1, "R5", "sample_valid latency (v0,v1)", {v0, v1}, 1);
    chk(l1 == ypat(0) && c1 == cbpat(0), "R5", "first pair luma/chroma",
        {l1, c1}, {ypat(0), cbpat(0)});
  endtask

  task automatic t_basic_525();
    do_reset();
    lane_hi = 1'b0; std625 = 1'b0;
    for (int i = 0; i < 3; i++) send_line(1'b0, 1'b0, 1716);
    send_raw_code(status(1'b0, 1'b0, 1'b1));
    send_fill(6);
    chk(n_valid == 2160, "R5", "valid pulses on three lines", n_valid, 2160);
    chk(n_bad == 0, "R5", "luma/chroma pairing", bad_act, bad_exp);
    chk(n_sol == 3 && n_eol == 4, "R2", "line_start/line_end count",
        n_sol * 100 + n_eol, 304);
    chk(n_len == 0, "R8", "no length error at 1716 clocks", n_len, 0);
    chk(n_perr == 0, "R4", "no protection error on clean codes", n_perr, 0);
  endtask

  task automatic t_high_lane();
    do_reset();
    lane_hi = 1'b1; std625 = 1'b0;
    send_line(1'b0, 1'b0, 1716);
    send_raw_code(status(1'b0, 1'b0, 1'b1));
    send_fill(6);
    chk(n_valid == 720 && n_bad == 0, "R7", "high lane samples, low byte junk",
        n_valid, 720);
    chk(n_perr == 0 && n_eol == 2, "R7", "high lane codes found", n_eol, 2);
    lane_hi = 1'b0;
  endtask

  task automatic t_625_blank();
    do_reset();
    lane_hi = 1'b0; std625 = 1'b1;
    send_line(1'b1, 1'b1, 1728);
    send_line(1'b1, 1'b1, 1728);
    send_raw_code(status(1'b1, 1'b1, 1'b1));
    send_fill(6);
    chk(n_valid == 0, "R6", "no samples on blank lines", n_valid, 0);
    chk(field && vblank, "R3", "field/vblank from codes", {field, vblank}, 3);
    chk(n_len == 0 && n_sol == 2, "R8", "1728-clock lines accepted", n_len, 0);
    send_line(1'b0, 1'b0, 1728);
    send_fill(2);
    chk(!field && !vblank, "R3", "field/vblank follow new codes",
        {field, vblank}, 0);
  endtask

  task automatic t_len_err();
    do_reset();
    lane_hi = 1'b0; std625 = 1'b1;
    send_line(1'b0, 1'b0, 1716);
    send_line(1'b0, 1'b0, 1716);
    send_raw_code(status(1'b0, 1'b0, 1'b1));
    send_fill(6);
    chk(n_len == 2, "R9", "short lines flagged for 1728 standard", n_len, 2);
    do_reset();
    std625 = 1'b0;
    send_line(1'b0, 1'b0, 1716);
    send_line(1'b0, 1'b0, 1720);
    send_raw_code(status(1'b0, 1'b0, 1'b1));
    send_fill(6);
    chk(n_len == 1, "R9", "one long line flagged", n_len, 1);
  endtask

  task automatic t_prot();
    do_reset();
    lane_hi = 1'b0; std625 = 1'b0;
    send_raw_code(status(1'b1, 1'b1, 1'b1) ^ 8'h01);
    send_fill(4);
    chk(n_perr == 1 && n_eol == 0, "R4", "bad parity code ignored",
        n_perr * 10 + n_eol, 10);
    chk(!field && !vblank, "R4", "field/vblank unchanged", {field, vblank}, 0);
    send_raw_code(status(1'b1, 1'b0, 1'b0) & 8'h7F);
    send_fill(4);
    chk(n_perr == 2 && n_sol == 0, "R4", "bit7 clear code ignored",
        n_perr * 10 + n_sol, 20);
    send_raw_code(status(1'b1, 1'b1, 1'b1));
    send_fill(4);
    chk(n_perr == 2 && field && vblank, "R3", "good code after bad ones",
        n_perr * 10 + {field, vblank}, 23);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_basic_525();
    t_high_lane();
    t_625_blank();
    t_len_err();
    t_prot();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule